// File: doc/BRIEF.md
# Complementary Dead-Time PWM Counter Pair

This block produces three-phase complementary gate drive from two linked up/down counters. A leading counter starts at the dead-time value and a lagging counter starts at zero. Both count up to their own peak, reverse, and count back down, so the lead stays exactly the dead time above the lag through the whole triangle. Each phase compares the two counters against its own compare value. The high-side gate follows the lagging counter and the low-side gate follows the leading one, so the two are never on together and a dead band sits between them.

The cycle peak, the half-cycle peak and the compare values are written through one register port. With the buffer-enable input high, a write lands in a shadow register, and all shadows move to the active set together at one transfer point per period. When the run input falls, the counters fall back to their start values. When it rises again, counting restarts with no reprogramming.

Top module: `cpwm_pair`

## Requirements
- R1: While `run_i` is low, every clock edge loads the lead counter with the dead-time value, including a value written in that same cycle, and clears the lag counter to 0. Both counters then count upward next.
- R2: When `run_i` rises, counting resumes from the stop state with no writes. The first running edge gives lead = dead + 1 and lag = 1.
- R3: While running, the lag counter rises to the half-cycle value and falls back to 0. The lead counter rises to the cycle value and falls back to the dead-time value. Each counter changes by exactly 1 per clock, and lead − lag equals the dead time.
- R4: A write to the dead-time register (select code 2) while `run_i` is high is ignored.
- R5: With `buf_en_i` high, a write to the cycle (code 0), half-cycle (code 1) or compare register of phase i (code 3+i) changes only its shadow, and the active value stays in use.
- R6: With `buf_en_i` high, all shadows are copied to the active registers together. With `XFER_AT_PEAK` = 1 (the default), the copy happens at the edge where the rising lead counter reaches the cycle value. Otherwise it happens at the edge where the falling lag counter reaches 0.
- R7: With `buf_en_i` low, a write to code 0, 1 or 3+i updates the active register and its shadow at once.
- R8: Gate bit 2i is the high side of phase i. It is 1 one cycle after lag > compare[i]. Gate bit 2i+1 is the low side. It is 1 one cycle after lead ≤ compare[i].
- R9: The two gates of a phase are never 1 together. After one gate falls, the other stays 0 for at least the dead-time number of cycles.
- R10: One cycle after `run_i` is seen low, all gate outputs are 0.
- R11: When bit g of `gate_dis_i` is set, gate bit g is 0 from the next cycle on.
- R12: `aux_dis_i[0]` forces the high side of the last phase to 0, and `aux_dis_i[1]` forces its low side to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | 1 = count, 0 = stop and reload |
| buf_en_i | input | 1 | 1 = writes go to shadows and transfer at the chosen point |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | 0 cycle, 1 half-cycle, 2 dead time, 3+i compare of phase i |
| wr_data_i | input | CNT_W | Write data |
| gate_dis_i | input | 2*NPH | Per-gate force-off |
| aux_dis_i | input | 2 | Force-off for last phase high/low side |
| lead_cnt_o | output | CNT_W | Leading counter value |
| lag_cnt_o | output | CNT_W | Lagging counter value |
| gate_o | output | 2*NPH | Gate drive, 2i high side, 2i+1 low side of phase i |

## Verification
The assertions check the following on every cycle: the reload values while stopped, the fixed lead-to-lag spacing while running, gates off when stopped or disabled, the exclusion of the two gates in each phase, and that a buffered active value moves only at a transfer event. Other behaviour shows up only in the bench's scenarios, which follow a model step by step. These are the dead band measured in cycles on each edge, the automatic restart values, the peak moving only one period after a buffered period change, a buffered compare that has no effect before the peak, and a direct compare write that takes effect at once.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_CYCLE = 3'd0,
        SEL_HALF  = 3'd1,
        SEL_DEAD  = 3'd2,
        SEL_CMP0  = 3'd3
    } reg_sel_e;
endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NPH   = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           run,
    input  logic                           buf_en,
    input  logic                           xfer,
    input  logic                           wr_en,
    input  logic [SEL_W-1:0]               wr_sel,
    input  logic [CNT_W-1:0]               wr_data,
    output logic [CNT_W-1:0]               cyc_o,
    output logic [CNT_W-1:0]               half_o,
    output logic [CNT_W-1:0]               dead_o,
    output logic [CNT_W-1:0]               dead_nxt_o,
    output logic [NPH-1:0][CNT_W-1:0]      cmp_o
);
    localparam int CMP_BASE = int'(SEL_CMP0);

    typedef struct packed {
        logic [CNT_W-1:0]          cyc;
        logic [CNT_W-1:0]          cyc_sh;
        logic [CNT_W-1:0]          half;
        logic [CNT_W-1:0]          half_sh;
        logic [CNT_W-1:0]          dead;
        logic [NPH-1:0][CNT_W-1:0] cmp;
        logic [NPH-1:0][CNT_W-1:0] cmp_sh;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        // shadow set moves as one
        if (xfer && buf_en) begin
            bank_d.cyc  = bank_q.cyc_sh;
            bank_d.half = bank_q.half_sh;
            bank_d.cmp  = bank_q.cmp_sh;
        end
        if (wr_en) begin
            case (wr_sel)
                SEL_CYCLE: begin
                    bank_d.cyc_sh = wr_data;
                    if (!buf_en) bank_d.cyc = wr_data;
                end
                SEL_HALF: begin
                    bank_d.half_sh = wr_data;
                    if (!buf_en) bank_d.half = wr_data;
                end
                SEL_DEAD: begin
                    if (!run) bank_d.dead = wr_data;
                end
                default: begin
                    for (int i = 0; i < NPH; i++) begin
                        if (int'(wr_sel) == CMP_BASE + i) begin
                            bank_d.cmp_sh[i] = wr_data;
                            if (!buf_en) bank_d.cmp[i] = wr_data;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign cyc_o      = bank_q.cyc;
    assign half_o     = bank_q.half;
    assign dead_o     = bank_q.dead;
    assign dead_nxt_o = bank_d.dead;
    assign cmp_o      = bank_q.cmp;
endmodule

// File: rtl/cpwm_counters.sv
module cpwm_counters #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cyc,
    input  logic [CNT_W-1:0] half,
    input  logic [CNT_W-1:0] dead_nxt,
    output logic [CNT_W-1:0] lead_o,
    output logic [CNT_W-1:0] lag_o,
    output logic             peak_o,
    output logic             trough_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] lead;
        logic [CNT_W-1:0] lag;
        logic             lead_up;
        logic             lag_up;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d.lead    = dead_nxt;
            cnt_d.lag     = '0;
            cnt_d.lead_up = 1'b1;
            cnt_d.lag_up  = 1'b1;
        end else begin
            if (cnt_q.lead_up) begin
                if (cnt_q.lead >= cyc) begin
                    cnt_d.lead_up = 1'b0;
                    cnt_d.lead    = cnt_q.lead - ONE;
                end else begin
                    cnt_d.lead    = cnt_q.lead + ONE;
                end
            end else begin
                if (cnt_q.lead <= dead_nxt) begin
                    cnt_d.lead_up = 1'b1;
                    cnt_d.lead    = cnt_q.lead + ONE;
                end else begin
                    cnt_d.lead    = cnt_q.lead - ONE;
                end
            end
            if (cnt_q.lag_up) begin
                if (cnt_q.lag >= half) begin
                    cnt_d.lag_up = 1'b0;
                    cnt_d.lag    = cnt_q.lag - ONE;
                end else begin
                    cnt_d.lag    = cnt_q.lag + ONE;
                end
            end else begin
                if (cnt_q.lag == '0) begin
                    cnt_d.lag_up = 1'b1;
                    cnt_d.lag    = ONE;
                end else begin
                    cnt_d.lag    = cnt_q.lag - ONE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '{lead: '0, lag: '0, lead_up: 1'b1, lag_up: 1'b1};
        else        cnt_q <= cnt_d;
    end

    assign lead_o   = cnt_q.lead;
    assign lag_o    = cnt_q.lag;
    assign peak_o   = run && cnt_q.lead_up && (cnt_q.lead >= cyc);
    assign trough_o = run && !cnt_q.lag_up && (cnt_q.lag == '0);
endmodule

// File: rtl/cpwm_gate.sv
module cpwm_gate #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] lead,
    input  logic [CNT_W-1:0] lag,
    input  logic [CNT_W-1:0] cmp,
    input  logic [1:0]       dis,
    output logic             hi_o,
    output logic             lo_o
);
    typedef struct packed {
        logic hi;
        logic lo;
    } pair_t;

    pair_t pair_d, pair_q;

    always_comb begin
        pair_d.hi = run && (lag > cmp) && !dis[0];
        pair_d.lo = run && (lead <= cmp) && !dis[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pair_q <= '0;
        else        pair_q <= pair_d;
    end

    assign hi_o = pair_q.hi;
    assign lo_o = pair_q.lo;
endmodule

// File: rtl/cpwm_pair.sv
module cpwm_pair
    import cpwm_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int NPH          = 3,
    parameter bit XFER_AT_PEAK = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               buf_en_i,
    input  logic               wr_en_i,
    input  logic [SEL_W-1:0]   wr_sel_i,
    input  logic [CNT_W-1:0]   wr_data_i,
    input  logic [2*NPH-1:0]   gate_dis_i,
    input  logic [1:0]         aux_dis_i,
    output logic [CNT_W-1:0]   lead_cnt_o,
    output logic [CNT_W-1:0]   lag_cnt_o,
    output logic [2*NPH-1:0]   gate_o
);
    logic [CNT_W-1:0]          cyc_q, half_q, dead_q, dead_nxt;
    logic [NPH-1:0][CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0]          lead, lag;
    logic                      peak, trough, xfer;
    logic [NPH-1:0][1:0]       dis_w;
    logic [NPH-1:0]            hi_w, lo_w;

    assign xfer = XFER_AT_PEAK ? peak : trough;

    cpwm_regs #(.CNT_W(CNT_W), .NPH(NPH)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_i),
        .buf_en     (buf_en_i),
        .xfer       (xfer),
        .wr_en      (wr_en_i),
        .wr_sel     (wr_sel_i),
        .wr_data    (wr_data_i),
        .cyc_o      (cyc_q),
        .half_o     (half_q),
        .dead_o     (dead_q),
        .dead_nxt_o (dead_nxt),
        .cmp_o      (cmp_q)
    );

    cpwm_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_i),
        .cyc      (cyc_q),
        .half     (half_q),
        .dead_nxt (dead_nxt),
        .lead_o   (lead),
        .lag_o    (lag),
        .peak_o   (peak),
        .trough_o (trough)
    );

    for (genvar i = 0; i < NPH; i++) begin : g_ph
        if (i == NPH - 1) begin : g_last
            assign dis_w[i] = gate_dis_i[2*i +: 2] | aux_dis_i;
        end else begin : g_mid
            assign dis_w[i] = gate_dis_i[2*i +: 2];
        end
        cpwm_gate #(.CNT_W(CNT_W)) u_gate (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run_i),
            .lead  (lead),
            .lag   (lag),
            .cmp   (cmp_q[i]),
            .dis   (dis_w[i]),
            .hi_o  (hi_w[i]),
            .lo_o  (lo_w[i])
        );
        assign gate_o[2*i]   = hi_w[i];
        assign gate_o[2*i+1] = lo_w[i];
    end

    assign lead_cnt_o = lead;
    assign lag_cnt_o  = lag;
endmodule

// File: rtl/cpwm_pair_chk.sv
module cpwm_pair_chk #(
    parameter int CNT_W = 16,
    parameter int NPH   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             buf_en,
    input logic [2*NPH-1:0] gate_dis,
    input logic [1:0]       aux_dis,
    input logic [CNT_W-1:0] lead,
    input logic [CNT_W-1:0] lag,
    input logic [CNT_W-1:0] dead,
    input logic [CNT_W-1:0] cyc,
    input logic             xfer,
    input logic [2*NPH-1:0] gate
);
    // R1
    stop_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (lag == '0) && (lead == dead));

    // R3
    spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> (CNT_W'(lead - lag) == dead));

    // R10
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (gate == '0));

    // R6
    xfer_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(buf_en) && !$stable(cyc)) |-> $past(xfer));

    // R12
    aux_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aux_dis[0] |=> !gate[2*NPH-2]);

    // R12
    aux_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aux_dis[1] |=> !gate[2*NPH-1]);

    for (genvar i = 0; i < NPH; i++) begin : g_ph
        // R9
        excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate[2*i] && gate[2*i+1]));
    end

    for (genvar g = 0; g < 2*NPH; g++) begin : g_gt
        // R11
        force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gate_dis[g] |=> !gate[g]);
    end
endmodule

bind cpwm_pair cpwm_pair_chk #(.CNT_W(CNT_W), .NPH(NPH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_i),
    .buf_en   (buf_en_i),
    .gate_dis (gate_dis_i),
    .aux_dis  (aux_dis_i),
    .lead     (lead),
    .lag      (lag),
    .dead     (dead_q),
    .cyc      (cyc_q),
    .xfer     (xfer),
    .gate     (gate_o)
);

// File: tb/tb_cpwm_pair.sv
`timescale 1ns/1ps
module tb_cpwm_pair;
    localparam int W = 16;
    localparam int P = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_i = 1'b0, buf_en_i = 1'b0, wr_en_i = 1'b0;
    logic [2:0] wr_sel_i = '0;
    logic [W-1:0] wr_data_i = '0;
    logic [2*P-1:0] gate_dis_i = '0;
    logic [1:0] aux_dis_i = '0;
    logic [W-1:0] lead_cnt_o, lag_cnt_o;
    logic [2*P-1:0] gate_o;

    always #2 clk = ~clk;

    cpwm_pair dut (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .buf_en_i(buf_en_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .gate_dis_i(gate_dis_i), .aux_dis_i(aux_dis_i),
        .lead_cnt_o(lead_cnt_o), .lag_cnt_o(lag_cnt_o), .gate_o(gate_o)
    );

    int n_chk = 0, n_fail = 0, tick_no = 0;

    // reference model state
    logic [W-1:0] m_lead = '0, m_lag = '0, m_cyc = '0, m_half = '0, m_dead = '0;
    logic [W-1:0] m_cyc_sh = '0, m_half_sh = '0;
    logic [W-1:0] m_cmp[P], m_cmp_sh[P];
    logic m_lead_up = 1'b1, m_lag_up = 1'b1;
    logic [2*P-1:0] m_gate = '0, prev_gate = '0;
    int last_fall[2*P];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (tick %0d)", req, act, exp, tick_no);
        end
    endtask

    task automatic model_step();
        logic [2*P-1:0] ng;
        logic xf;
        logic [W-1:0] nl, ng_lag, dn;
        logic nlu, ngu;
        for (int i = 0; i < P; i++) begin
            logic dh, dl;
            dh = gate_dis_i[2*i]   | ((i == P-1) ? aux_dis_i[0] : 1'b0);
            dl = gate_dis_i[2*i+1] | ((i == P-1) ? aux_dis_i[1] : 1'b0);
            ng[2*i]   = run_i && (m_lag > m_cmp[i]) && !dh;
            ng[2*i+1] = run_i && (m_lead <= m_cmp[i]) && !dl;
        end
        xf = run_i && m_lead_up && (m_lead >= m_cyc);
        dn = (wr_en_i && wr_sel_i == 3'd2 && !run_i) ? wr_data_i : m_dead;
        nl = m_lead; ng_lag = m_lag; nlu = m_lead_up; ngu = m_lag_up;
        if (!run_i) begin
            nl = dn; ng_lag = '0; nlu = 1'b1; ngu = 1'b1;
        end else begin
            if (m_lead_up) begin
                if (m_lead >= m_cyc) begin nlu = 1'b0; nl = m_lead - 1; end
                else nl = m_lead + 1;
            end else begin
                if (m_lead <= dn) begin nlu = 1'b1; nl = m_lead + 1; end
                else nl = m_lead - 1;
            end
            if (m_lag_up) begin
                if (m_lag >= m_half) begin ngu = 1'b0; ng_lag = m_lag - 1; end
                else ng_lag = m_lag + 1;
            end else begin
                if (m_lag == 0) begin ngu = 1'b1; ng_lag = 1; end
                else ng_lag = m_lag - 1;
            end
        end
        if (xf && buf_en_i) begin
            m_cyc = m_cyc_sh; m_half = m_half_sh;
            for (int i = 0; i < P; i++) m_cmp[i] = m_cmp_sh[i];
        end
        if (wr_en_i) begin
            case (wr_sel_i)
                3'd0: begin m_cyc_sh = wr_data_i; if (!buf_en_i) m_cyc = wr_data_i; end
                3'd1: begin m_half_sh = wr_data_i; if (!buf_en_i) m_half = wr_data_i; end
                3'd2: ;
                default: if (int'(wr_sel_i) - 3 < P) begin
                    m_cmp_sh[int'(wr_sel_i)-3] = wr_data_i;
                    if (!buf_en_i) m_cmp[int'(wr_sel_i)-3] = wr_data_i;
                end
            endcase
        end
        m_dead = dn;
        m_lead = nl; m_lag = ng_lag; m_lead_up = nlu; m_lag_up = ngu;
        m_gate = ng;
    endtask

    // one clock: model advances at the edge, outputs compared mid-cycle
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        tick_no++;
        chk(lead_cnt_o == m_lead, "R3 lead counter", lead_cnt_o, m_lead);
        chk(lag_cnt_o == m_lag, "R3 lag counter", lag_cnt_o, m_lag);
        chk(gate_o == m_gate, "R8 gate pattern", gate_o, m_gate);
        for (int i = 0; i < P; i++) begin
            chk(!(gate_o[2*i] && gate_o[2*i+1]), "R9 exclusion", gate_o[2*i+:2], 0);
        end
        for (int g = 0; g < 2*P; g++) begin
            int pr;
            pr = g ^ 1;
            if (prev_gate[g] && !gate_o[g]) last_fall[g] = tick_no;
            if (!prev_gate[g] && gate_o[g] && last_fall[pr] >= 0)
                chk(tick_no - last_fall[pr] >= int'(m_dead), "R9 dead band",
                    tick_no - last_fall[pr], int'(m_dead));
        end
        prev_gate = gate_o;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [W-1:0] data);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
        tick();
        wr_en_i = 1'b0;
    endtask

    task automatic run_until(input int lagv, input bit up);
        for (int k = 0; k < 400; k++) begin
            if (m_lag == W'(lagv) && m_lag_up == up) break;
            tick();
        end
    endtask

    task automatic t_reset();
        chk(lead_cnt_o == 0, "R1 reset lead", lead_cnt_o, 0);
        chk(lag_cnt_o == 0, "R1 reset lag", lag_cnt_o, 0);
        chk(gate_o == 0, "R10 reset gates", gate_o, 0);
    endtask

    task automatic t_stop_load();
        wr(3'd0, 16'd23); wr(3'd1, 16'd20);
        wr(3'd3, 16'd5); wr(3'd4, 16'd10); wr(3'd5, 16'd15);
        wr(3'd2, 16'd3);
        // R1: the dead value written in this cycle already appears
        chk(lead_cnt_o == 3, "R1 lead loads dead", lead_cnt_o, 3);
        chk(lag_cnt_o == 0, "R1 lag cleared", lag_cnt_o, 0);
        tick();
        chk(lead_cnt_o == 3, "R1 lead held", lead_cnt_o, 3);
    endtask

    task automatic t_run_restart();
        run_i = 1'b1;
        tick();
        chk(lead_cnt_o == 4 && lag_cnt_o == 1, "R2 first run step", lag_cnt_o, 1);
        for (int k = 0; k < 90; k++) tick();
        run_until(12, 1'b0);
        run_i = 1'b0;
        tick();
        chk(lead_cnt_o == 3, "R1 stop lead", lead_cnt_o, 3);
        chk(lag_cnt_o == 0, "R1 stop lag", lag_cnt_o, 0);
        chk(gate_o == 0, "R10 stop gates", gate_o, 0);
        for (int k = 0; k < 5; k++) tick();
        run_i = 1'b1;
        tick();
        chk(lead_cnt_o == 4, "R2 restart lead", lead_cnt_o, 4);
        chk(lag_cnt_o == 1, "R2 restart lag", lag_cnt_o, 1);
        tick();
        chk(lag_cnt_o == 2, "R2 restart keeps counting", lag_cnt_o, 2);
    endtask

    task automatic t_dead_lock();
        wr(3'd2, 16'd7);
        tick(); tick();
        chk(int'(lead_cnt_o - lag_cnt_o) == 3, "R4 dead write ignored", lead_cnt_o - lag_cnt_o, 3);
        run_i = 1'b0;
        tick();
        chk(lead_cnt_o == 3, "R4 stop keeps old dead", lead_cnt_o, 3);
        for (int k = 0; k < 4; k++) tick();
        run_i = 1'b1;
    endtask

    task automatic t_buffered();
        int mx;
        buf_en_i = 1'b1;
        run_until(8, 1'b1);
        wr(3'd3, 16'd12);
        tick();
        chk(gate_o[0] == 1'b1, "R5 compare shadowed", gate_o[0], 1);
        run_until(11, 1'b0);
        tick();
        chk(gate_o[0] == 1'b0, "R6 compare moved at peak", gate_o[0], 0);
        run_until(6, 1'b1);
        wr(3'd1, 16'd24); wr(3'd0, 16'd27);
        mx = 0;
        for (int k = 0; k < 60 && !(m_lag_up == 1'b0 && m_lag < 5); k++) begin
            tick();
            if (int'(lag_cnt_o) > mx) mx = int'(lag_cnt_o);
        end
        chk(mx == 20, "R5 period unchanged this cycle", mx, 20);
        run_until(1, 1'b1);
        mx = 0;
        for (int k = 0; k < 60 && !(m_lag_up == 1'b0 && m_lag < 5); k++) begin
            tick();
            if (int'(lag_cnt_o) > mx) mx = int'(lag_cnt_o);
        end
        chk(mx == 24, "R6 new period after transfer", mx, 24);
        buf_en_i = 1'b0;
    endtask

    task automatic t_direct();
        run_until(7, 1'b1);
        wr(3'd4, 16'd4);
        tick();
        chk(gate_o[2] == 1'b1, "R7 direct compare immediate", gate_o[2], 1);
    endtask

    task automatic t_disable();
        bit seen_a, seen_b;
        run_i = 1'b0;
        for (int k = 0; k < 4; k++) tick();
        gate_dis_i = 6'b000100;
        run_i = 1'b1;
        seen_a = 0; seen_b = 0;
        for (int k = 0; k < 60; k++) begin
            tick();
            if (gate_o[2]) seen_a = 1;
            if (gate_o[3]) seen_b = 1;
        end
        chk(!seen_a, "R11 disabled gate stays low", seen_a, 0);
        chk(seen_b, "R11 partner unaffected", seen_b, 1);
        run_i = 1'b0;
        for (int k = 0; k < 4; k++) tick();
        gate_dis_i = '0; aux_dis_i = 2'b01;
        run_i = 1'b1;
        seen_a = 0; seen_b = 0;
        for (int k = 0; k < 60; k++) begin
            tick();
            if (gate_o[4]) seen_a = 1;
            if (gate_o[5]) seen_b = 1;
        end
        chk(!seen_a && seen_b, "R12 aux bit0 blocks high side", {seen_a, seen_b}, 1);
        run_i = 1'b0;
        for (int k = 0; k < 4; k++) tick();
        aux_dis_i = 2'b10;
        run_i = 1'b1;
        seen_a = 0; seen_b = 0;
        for (int k = 0; k < 60; k++) begin
            tick();
            if (gate_o[4]) seen_a = 1;
            if (gate_o[5]) seen_b = 1;
        end
        chk(seen_a && !seen_b, "R12 aux bit1 blocks low side", {seen_a, seen_b}, 2);
        run_i = 1'b0;
        tick();
        chk(gate_o == 0, "R10 gates off after stop", gate_o, 0);
    endtask

    initial begin
        for (int i = 0; i < P; i++) begin m_cmp[i] = '0; m_cmp_sh[i] = '0; end
        for (int g = 0; g < 2*P; g++) last_fall[g] = -1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stop_load();
        t_run_restart();
        t_dead_lock();
        t_buffered();
        t_direct();
        t_disable();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", tick_no, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule